// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits next to a small CPU core and decides, cycle by cycle, whether the core must leave its current instruction stream. It watches a reset request, a non-maskable interrupt request and a set of level-sensitive maskable request lines. It also owns the processor status word and the exception cause and context registers. When it accepts an event, it saves the core's current program counter and status word into the matching context pair. It then updates the status flags and the cause halfword, and pulses a redirect strobe together with the new fetch address.

A return strobe from the core undoes the most recent entry. The block chooses the context pair to restore from the non-maskable-in-progress flag. A non-maskable request that arrives while one is already being serviced is remembered once and retried on every cycle. Maskable requests are never latched. They stay asserted by their source until the block returns a one-cycle acknowledge for that line.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A reset request causes, on the next cycle, a redirect to address 0, status word 0x20 and cause register 0, and discards any held non-maskable request.
- R2: The status word bits are NP=7, EP=6, ID=5, SAT=4, CY=3, OV=2, S=1 and Z=0. After block reset the status word is 0x20, all other registers are 0, and there is neither a redirect nor an acknowledge.
- R3: A non-maskable entry copies the current PC into the NMI return PC and the status word into the NMI saved status. It sets NP and ID, clears EP, writes 0x0010 into cause bits 31:16 and keeps bits 15:0. It redirects to 0x10 in the cycle after the request.
- R4: A non-maskable request seen while NP is set is held as a single pending event and taken on the first cycle in which NP is clear. Extra requests during the wait add no further entries.
- R5: Maskable entry is blocked while NP or ID is set. A blocked request line stays pending, produces no acknowledge and is taken once both flags are clear.
- R6: A maskable entry copies the PC into the interrupt return PC and the status word into the interrupt saved status. It sets ID, clears EP, writes the vector into cause bits 15:0 and keeps bits 31:16. It pulses the acknowledge bit of the chosen line for one cycle, together with the redirect.
- R7: The vector of maskable line i is 0x80 + 0x10*i (0x80 to 0xD0 for six lines). When several lines are pending, the lowest index is taken.
- R8: Priority within one cycle is reset request, then return strobe, then non-maskable request, then maskable requests. Only one event is acted on per cycle.
- R9: A return strobe redirects to the NMI return PC and restores the NMI saved status when NP is set. Otherwise it uses the interrupt return PC and the interrupt saved status.
- R10: The redirect strobe is high for exactly the one cycle that follows each accepted event and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| reset_req | input | 1 | Processor reset request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 6 | Level-sensitive maskable request lines |
| cur_pc | input | 32 | Current PC of the core |
| reti | input | 1 | Return-from-interrupt strobe |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch address that goes with the redirect |
| irq_ack_o | output | 6 | One-cycle acknowledge per maskable line |
| psw_o | output | 8 | Processor status word |
| ecr_o | output | 32 | Cause register (31:16 NMI code, 15:0 maskable code) |
| eipc_o | output | 32 | Maskable-interrupt return PC |
| eipsw_o | output | 8 | Maskable-interrupt saved status |
| fepc_o | output | 32 | Non-maskable return PC |
| fepsw_o | output | 8 | Non-maskable saved status |

## Verification
The per-cycle properties cover the reset-request outcome, the flag and cause-code pattern after a non-maskable entry, and the rule that the NMI context stays untouched while NP is set. They also check that no acknowledge appears while NP or ID blocks maskable entry, that acknowledges are one-hot and always come with a redirect, and that a return strobe always redirects. Only the bench scenarios can show the behaviour that spans several events. These are the single held NMI taken after a return clears NP, the order between lines pending together, and the choice of which context pair a return restores. The bench tracks these with a cycle-level reference model.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef struct packed {
        logic np;
        logic ep;
        logic id;
        logic sat;
        logic cy;
        logic ov;
        logic s;
        logic z;
    } psw_t;

    localparam logic [7:0]  PSW_RESET_VAL  = 8'h20;
    localparam logic [15:0] NMI_CAUSE_CODE = 16'h0010;
    localparam logic [15:0] NMI_VECTOR     = 16'h0010;
    localparam logic [15:0] MASK_VEC_BASE  = 16'h0080;
    localparam logic [15:0] MASK_VEC_STEP  = 16'h0010;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_RESET = 3'd1,
        EV_RETI  = 3'd2,
        EV_NMI   = 3'd3,
        EV_MASK  = 3'd4
    } ev_kind_e;

    function automatic logic [15:0] mask_vector(input int unsigned idx);
        return 16'(MASK_VEC_BASE + MASK_VEC_STEP * idx);
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NSRC  = 6,
    parameter int SRC_W = 3
) (
    input  logic             reset_req,
    input  logic             reti,
    input  logic             nmi_want,
    input  logic [NSRC-1:0]  irq_req,
    input  psw_t             psw,
    output ev_kind_e         kind,
    output logic [SRC_W-1:0] src,
    output logic [NSRC-1:0]  grant
);

    logic any_irq;
    logic [NSRC-1:0] lowest;

    assign any_irq = |irq_req;

    // lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        src = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (irq_req[i]) src = SRC_W'(i);
        end
    end

    always_comb begin
        lowest = '0;
        if (any_irq) lowest[src] = 1'b1;
    end

    always_comb begin
        if (reset_req)
            kind = EV_RESET;
        else if (reti)
            kind = EV_RETI;
        else if (nmi_want && !psw.np)
            kind = EV_NMI;
        else if (any_irq && !psw.np && !psw.id)
            kind = EV_MASK;
        else
            kind = EV_NONE;
    end

    assign grant = (kind == EV_MASK) ? lowest : '0;

endmodule

// File: rtl/irq_nmi_hold.sv
module irq_nmi_hold (
    input  logic clk,
    input  logic rst,
    input  logic reset_req,
    input  logic nmi_req,
    input  logic take_nmi,
    output logic nmi_want
);

    logic pend_q;

    assign nmi_want = nmi_req | pend_q;

    // a single held request; repeats while waiting collapse into it
    always_ff @(posedge clk) begin
        if (rst || reset_req)
            pend_q <= 1'b0;
        else if (take_nmi)
            pend_q <= 1'b0;
        else if (nmi_req)
            pend_q <= 1'b1;
    end

endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
    import irq_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int NSRC  = 6,
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  ev_kind_e         kind,
    input  logic [SRC_W-1:0] src,
    input  logic [NSRC-1:0]  grant,
    input  logic [PC_W-1:0]  cur_pc,
    output psw_t             psw_q,
    output logic [31:0]      ecr_q,
    output logic [PC_W-1:0]  eipc_q,
    output psw_t             eipsw_q,
    output logic [PC_W-1:0]  fepc_q,
    output psw_t             fepsw_q,
    output logic             redirect_q,
    output logic [PC_W-1:0]  redirect_pc_q,
    output logic [NSRC-1:0]  ack_q
);

    localparam int PAD_W = PC_W - 16;

    function automatic logic [PC_W-1:0] widen(input logic [15:0] v);
        return {{PAD_W{1'b0}}, v};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q         <= psw_t'(PSW_RESET_VAL);
            ecr_q         <= '0;
            eipc_q        <= '0;
            eipsw_q       <= '0;
            fepc_q        <= '0;
            fepsw_q       <= '0;
            redirect_q    <= 1'b0;
            redirect_pc_q <= '0;
            ack_q         <= '0;
        end else begin
            redirect_q <= 1'b0;
            ack_q      <= '0;
            unique case (kind)
                EV_RESET: begin
                    psw_q         <= psw_t'(PSW_RESET_VAL);
                    ecr_q         <= '0;
                    redirect_q    <= 1'b1;
                    redirect_pc_q <= '0;
                end
                EV_RETI: begin
                    redirect_q <= 1'b1;
                    if (psw_q.np) begin
                        redirect_pc_q <= fepc_q;
                        psw_q         <= fepsw_q;
                    end else begin
                        redirect_pc_q <= eipc_q;
                        psw_q         <= eipsw_q;
                    end
                end
                EV_NMI: begin
                    fepc_q        <= cur_pc;
                    fepsw_q       <= psw_q;
                    psw_q.np      <= 1'b1;
                    psw_q.ep      <= 1'b0;
                    psw_q.id      <= 1'b1;
                    ecr_q[31:16]  <= NMI_CAUSE_CODE;
                    redirect_q    <= 1'b1;
                    redirect_pc_q <= widen(NMI_VECTOR);
                end
                EV_MASK: begin
                    eipc_q        <= cur_pc;
                    eipsw_q       <= psw_q;
                    psw_q.id      <= 1'b1;
                    psw_q.ep      <= 1'b0;
                    ecr_q[15:0]   <= mask_vector(32'(src));
                    ack_q         <= grant;
                    redirect_q    <= 1'b1;
                    redirect_pc_q <= widen(mask_vector(32'(src)));
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reset_req,
    input  logic            nmi_req,
    input  logic [NSRC-1:0] irq_req,
    input  logic [PC_W-1:0] cur_pc,
    input  logic            reti,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic [NSRC-1:0] irq_ack_o,
    output logic [7:0]      psw_o,
    output logic [31:0]     ecr_o,
    output logic [PC_W-1:0] eipc_o,
    output logic [7:0]      eipsw_o,
    output logic [PC_W-1:0] fepc_o,
    output logic [7:0]      fepsw_o
);

    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    ev_kind_e         ev_kind;
    logic [SRC_W-1:0] ev_src;
    logic [NSRC-1:0]  ev_grant;
    logic             nmi_want;
    psw_t             psw_q, eipsw_q, fepsw_q;

    irq_nmi_hold u_nmi (
        .clk       (clk),
        .rst       (rst),
        .reset_req (reset_req),
        .nmi_req   (nmi_req),
        .take_nmi  (ev_kind == EV_NMI),
        .nmi_want  (nmi_want)
    );

    irq_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
        .reset_req (reset_req),
        .reti      (reti),
        .nmi_want  (nmi_want),
        .irq_req   (irq_req),
        .psw       (psw_q),
        .kind      (ev_kind),
        .src       (ev_src),
        .grant     (ev_grant)
    );

    irq_ctx_regs #(.PC_W(PC_W), .NSRC(NSRC), .SRC_W(SRC_W)) u_ctx (
        .clk           (clk),
        .rst           (rst),
        .kind          (ev_kind),
        .src           (ev_src),
        .grant         (ev_grant),
        .cur_pc        (cur_pc),
        .psw_q         (psw_q),
        .ecr_q         (ecr_o),
        .eipc_q        (eipc_o),
        .eipsw_q       (eipsw_q),
        .fepc_q        (fepc_o),
        .fepsw_q       (fepsw_q),
        .redirect_q    (redirect_o),
        .redirect_pc_q (redirect_pc_o),
        .ack_q         (irq_ack_o)
    );

    assign psw_o   = psw_q;
    assign eipsw_o = eipsw_q;
    assign fepsw_o = fepsw_q;

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk
    import irq_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int NSRC = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            reset_req,
    input logic            reti,
    input logic [2:0]      kind,
    input logic            redirect_o,
    input logic [PC_W-1:0] redirect_pc_o,
    input logic [NSRC-1:0] irq_ack_o,
    input logic [7:0]      psw_o,
    input logic [31:0]     ecr_o,
    input logic [PC_W-1:0] fepc_o,
    input logic [7:0]      fepsw_o
);

    a_r1_reset_outcome: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> (redirect_o && redirect_pc_o == '0 && psw_o == 8'h20 && ecr_o == 32'h0));

    a_r3_nmi_flags: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_NMI) |=> (psw_o[7] && psw_o[5] && !psw_o[6]
                              && ecr_o[31:16] == 16'h0010 && redirect_pc_o == PC_W'(16'h0010)));

    a_r4_nmi_ctx_frozen: assert property (@(posedge clk) disable iff (rst)
        (psw_o[7] && !reset_req && !reti) |=> ($stable(fepc_o) && $stable(fepsw_o)));

    a_r5_mask_blocked: assert property (@(posedge clk) disable iff (rst)
        ((psw_o[7] || psw_o[5]) && !reset_req && !reti) |=> (irq_ack_o == '0));

    a_r6_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack_o));

    a_r6_ack_redirect: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack_o) |-> (redirect_o && psw_o[5]));

    a_r9_reti_redirect: assert property (@(posedge clk) disable iff (rst)
        reti |=> (redirect_o && irq_ack_o == '0));

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.PC_W(PC_W), .NSRC(NSRC)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .reset_req     (reset_req),
    .reti          (reti),
    .kind          (ev_kind),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .irq_ack_o     (irq_ack_o),
    .psw_o         (psw_o),
    .ecr_o         (ecr_o),
    .fepc_o        (fepc_o),
    .fepsw_o       (fepsw_o)
);

// File: tb/irq_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb_top;

    localparam int NSRC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [5:0]  irq_req = '0;
    logic [31:0] cur_pc = '0;
    logic        reti = 1'b0;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic [5:0]  irq_ack_o;
    logic [7:0]  psw_o, eipsw_o, fepsw_o;
    logic [31:0] ecr_o, eipc_o, fepc_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    irq_entry_ctrl dut_i (
        .clk(clk), .rst(rst), .reset_req(reset_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .cur_pc(cur_pc), .reti(reti),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .irq_ack_o(irq_ack_o), .psw_o(psw_o), .ecr_o(ecr_o),
        .eipc_o(eipc_o), .eipsw_o(eipsw_o), .fepc_o(fepc_o), .fepsw_o(fepsw_o)
    );

    // reference state derived from the requirements
    logic [7:0]  m_psw = 8'h20, m_eipsw = '0, m_fepsw = '0;
    logic [31:0] m_ecr = '0, m_eipc = '0, m_fepc = '0, m_rpc = '0;
    logic        m_pend = 1'b0, m_redir = 1'b0;
    logic [5:0]  m_ack = '0;

    function automatic logic [15:0] vec_of(input int i);
        return 16'(16'h0080 + 16'h0010 * i);
    endfunction

    task automatic model();
        m_redir = 1'b0;
        m_ack   = '0;
        if (reset_req) begin
            m_psw = 8'h20; m_ecr = '0; m_pend = 1'b0;
            m_redir = 1'b1; m_rpc = '0;
        end else if (reti) begin
            m_redir = 1'b1;
            if (m_psw[7]) begin m_rpc = m_fepc; m_psw = m_fepsw; end
            else          begin m_rpc = m_eipc; m_psw = m_eipsw; end
            if (nmi_req) m_pend = 1'b1;
        end else if ((nmi_req || m_pend) && !m_psw[7]) begin
            m_fepc = cur_pc; m_fepsw = m_psw;
            m_psw = (m_psw | 8'hA0) & 8'hBF;
            m_ecr[31:16] = 16'h0010;
            m_redir = 1'b1; m_rpc = 32'h10; m_pend = 1'b0;
        end else if ((|irq_req) && !m_psw[7] && !m_psw[5]) begin
            int sel = 0;
            for (int i = NSRC - 1; i >= 0; i--) if (irq_req[i]) sel = i;
            m_eipc = cur_pc; m_eipsw = m_psw;
            m_psw = (m_psw | 8'h20) & 8'hBF;
            m_ecr[15:0] = vec_of(sel);
            m_ack[sel] = 1'b1;
            m_redir = 1'b1; m_rpc = {16'h0, vec_of(sel)};
        end else if (nmi_req) begin
            m_pend = 1'b1;
        end
    endtask

    task automatic chk(input string tag, input string field, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, field, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "redirect R10", {31'h0, redirect_o}, {31'h0, m_redir});
        if (m_redir) chk(tag, "redirect_pc R7", redirect_pc_o, m_rpc);
        chk(tag, "ack R6", {26'h0, irq_ack_o}, {26'h0, m_ack});
        chk(tag, "psw R2", {24'h0, psw_o}, {24'h0, m_psw});
        chk(tag, "ecr R3", ecr_o, m_ecr);
        chk(tag, "eipc R6", eipc_o, m_eipc);
        chk(tag, "eipsw R6", {24'h0, eipsw_o}, {24'h0, m_eipsw});
        chk(tag, "fepc R3", fepc_o, m_fepc);
        chk(tag, "fepsw R3", {24'h0, fepsw_o}, {24'h0, m_fepsw});
    endtask

    // one clock: model, edge, compare, then release acknowledged lines
    task automatic step(input string tag);
        model();
        @(posedge clk); #1;
        check_all(tag);
        irq_req = irq_req & ~irq_ack_o;
        reset_req = 1'b0; nmi_req = 1'b0; reti = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R2: block reset state
        chk("R2", "psw reset", {24'h0, psw_o}, 32'h20);
        check_all("R2");

        // R9: return with NP clear restores the maskable pair (zeros)
        reti = 1'b1; step("R9");
        chk("R9", "psw restored", {24'h0, psw_o}, 32'h0);

        // R7: lines 3 and 5 pending, lowest taken at 0xB0
        irq_req = 6'b101000; cur_pc = 32'h1234; step("R7");
        chk("R7", "vector line3", redirect_pc_o, 32'hB0);
        chk("R6", "ack line3", {26'h0, irq_ack_o}, 32'h08);

        // R5: line 5 still high but ID set
        step("R5"); step("R5");

        // R3: NMI entry
        nmi_req = 1'b1; cur_pc = 32'h2000; step("R3");
        chk("R3", "nmi vector", redirect_pc_o, 32'h10);
        chk("R3", "ecr", ecr_o, 32'h001000B0);

        // R4: two more NMIs while NP set: held once
        nmi_req = 1'b1; cur_pc = 32'h3000; step("R4");
        step("R4");
        nmi_req = 1'b1; step("R4");
        reti = 1'b1; step("R9");
        cur_pc = 32'h4000; step("R4");
        chk("R4", "held nmi taken", fepc_o, 32'h4000);
        reti = 1'b1; step("R4");
        step("R4");
        chk("R4", "no second nmi", {31'h0, redirect_o}, 32'h0);

        // R1 / R8: reset request beats NMI, drops held NMI
        nmi_req = 1'b1; reset_req = 1'b1; step("R1");
        chk("R1", "reset pc", redirect_pc_o, 32'h0);
        step("R1");
        step("R1");

        // R8: return beats NMI, NMI beats maskable
        irq_req = 6'b000001;
        reti = 1'b1; nmi_req = 1'b1; step("R8");
        step("R8");
        chk("R8", "nmi over maskable", redirect_pc_o, 32'h10);
        reti = 1'b1; step("R8");
        step("R7");
        chk("R7", "vector line0", redirect_pc_o, 32'h80);
        irq_req = 6'b100000; reti = 1'b1; step("R9");
        step("R7");
        chk("R7", "vector line5", redirect_pc_o, 32'hD0);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            reset_req = ($urandom % 300) == 0;
            nmi_req   = ($urandom % 23) == 0;
            reti      = ($urandom % 5) == 0;
            cur_pc    = $urandom;
            for (int i = 0; i < NSRC; i++)
                if (($urandom % 8) == 0) irq_req[i] = 1'b1;
            step("R10");
        end
        finish_run();
    end

endmodule